// File: doc/BRIEF.md
# Scanline Sprite Attribute Evaluator

This block prepares the sprite data for one video line. On a start-of-line pulse it walks a 32-entry sprite attribute table in video memory in ascending sprite order. For each sprite it reads only the vertical position byte and decides from that byte alone whether the sprite covers the target line. Every sprite it selects gets a fixed budget of six further byte reads: the four attribute bytes (vertical, horizontal, pattern name, colour) and two pattern bytes. These are loaded into one of four slot register sets that a later pixel stage consumes.

A vertical byte of 0xD0 ends the walk. When a fifth covering sprite is found, the block raises a sticky overflow flag and stores that sprite's number, then stops. Size (8x8 or 16x16) and magnification select the sprite height and the pattern row.

Video memory is reached through a request channel with valid/ready and a response channel with valid only. `rd_addr` is held stable while `rd_req_valid` is high and `rd_req_ready` is low. At most one read is outstanding. The memory must return exactly one response per accepted request, at least one cycle after acceptance. The block always accepts the response, so the response channel has no back-pressure.

Top module: `sprite_line_eval`

## Requirements
- R1: After `line_start`, sprite n (0..31, ascending) is probed with one read at address `{sat_base, n[4:0], 2'b00}`. A sprite that does not cover the line costs exactly that one read.
- R2: A probed vertical byte of 0xD0 ends the walk. `done` rises, and no read of that sprite or of any higher sprite follows.
- R3: A sprite covers the line when off = (line_num - (ypos + 1)) mod 256 is below the height. The height is 8, or 16 when `size16` is set, and it doubles when `mag` is set. The horizontal byte and the colour byte play no part in this decision.
- R4: A covering sprite that gets a slot costs six more reads, in this order: attribute bytes 0, 1, 2 and 3 at `{sat_base, n, byte}`, then two pattern reads. The results load that slot's ypos, xpos, name, colour, left pattern and right pattern fields.
- R5: The pattern row is off, or off>>1 when `mag` is set. In 8x8 mode both pattern reads use `{pat_base, name, row[2:0]}`, and the right pattern field is loaded with 0. In 16x16 mode the reads use `{pat_base, name[7:2], col, row[3:0]}`, with col=0 for the left byte and col=1 for the right byte.
- R6: At most four slots are filled, in ascending sprite order. `slot_valid` fills from bit 0 upward, and bit k rises when slot k's last field is loaded.
- R7: A covering sprite found while all four slots are full sets `fifth_flag`, stores that sprite's number in `fifth_num` if the flag was clear, and ends the walk with `done`.
- R8: While `fifth_flag` is set, later lines do not change `fifth_num`. A `status_rd` pulse clears the flag. If a new overflow and `status_rd` fall in the same cycle, the flag stays set.
- R9: Without a terminator or an overflow, the walk ends with `done` after sprite 31 has been handled, including its six reads if it takes a slot.
- R10: `line_start` clears all slot fields and `slot_valid`, drops `done` and restarts at sprite 0. After reset, `done`, `slot_valid`, `fifth_flag` and `rd_req_valid` are all 0.
- R11: While `rd_req_valid` is high and `rd_req_ready` is low, the request stays asserted and `rd_addr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | One-cycle pulse that starts evaluation for `line_num` |
| line_num | input | 8 | Target scanline |
| sat_base | input | 7 | Attribute table base, in units of 128 bytes |
| pat_base | input | 3 | Pattern table base, in units of 2 KiB |
| size16 | input | 1 | 1 selects 16x16 sprites |
| mag | input | 1 | 1 doubles sprite height |
| status_rd | input | 1 | Pulse that clears the overflow flag |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_addr | output | 14 | Byte address of the read |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 8 | Read data |
| slot_valid | output | 4 | Slot loaded flags |
| slot_ypos | output | 32 | Per-slot vertical byte, slot k in bits [8k+7:8k] |
| slot_xpos | output | 32 | Per-slot horizontal byte |
| slot_name | output | 32 | Per-slot pattern name |
| slot_color | output | 32 | Per-slot colour byte |
| slot_pat_l | output | 32 | Per-slot left pattern byte |
| slot_pat_r | output | 32 | Per-slot right pattern byte (0 in 8x8 mode) |
| fifth_flag | output | 1 | Sticky fifth-sprite overflow flag |
| fifth_num | output | 5 | Number of the overflowing sprite |
| done | output | 1 | Walk for the current line finished |

## Verification
The assertions rely on two input rules. First, `line_start` never arrives while a read response is still owed. Second, the memory answers each accepted request exactly once and never before acceptance. They also assume that `size16`, `mag` and the base inputs stay constant during a walk. The bench memory model respects these rules. It pulses `line_start` only after `done`, inserts random ready stalls and response delays of one to three cycles, and changes configuration only between lines. The scoreboard predicts the exact address stream of each line from the attribute table contents.

// File: rtl/sprite_eval_pkg.sv
package sprite_eval_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned STEP_W      = 3;
  localparam int unsigned LAST_STEP   = 6;
  localparam logic [7:0]  END_MARKER  = 8'hD0;

  typedef enum logic [1:0] {
    EV_IDLE,
    EV_REQ,
    EV_WAIT,
    EV_DONE
  } ev_state_t;
endpackage

// File: rtl/spr_vcheck.sv
module spr_vcheck (
  input  logic [7:0] line_num,
  input  logic [7:0] ypos,
  input  logic       size16,
  input  logic       mag,
  output logic       act,
  output logic [3:0] row
);
  logic [7:0] off;
  logic [7:0] height;

  always_comb begin
    off    = line_num - ypos - 8'd1;
    height = size16 ? 8'd16 : 8'd8;
    if (mag) height = {height[6:0], 1'b0};
    act    = off < height;
    row    = mag ? off[4:1] : off[3:0];
  end
endmodule

// File: rtl/spr_addr_gen.sv
module spr_addr_gen #(
  parameter int unsigned VA_W  = 14,
  parameter int unsigned IDX_W = 5,
  localparam int unsigned SAT_W = VA_W - IDX_W - 2,
  localparam int unsigned PAT_W = VA_W - 11
) (
  input  logic [SAT_W-1:0] sat_base,
  input  logic [PAT_W-1:0] pat_base,
  input  logic [IDX_W-1:0] idx,
  input  logic [2:0]       step,
  input  logic [7:0]       name,
  input  logic [3:0]       row,
  input  logic             size16,
  output logic [VA_W-1:0]  addr
);
  logic [1:0] attr_byte;
  logic       col;

  always_comb begin
    attr_byte = step[1:0] - 2'd1;
    col       = (step == 3'd6);
    if (step == 3'd0)
      addr = {sat_base, idx, 2'b00};
    else if (step <= 3'd4)
      addr = {sat_base, idx, attr_byte};
    else if (size16)
      addr = {pat_base, name[7:2], col, row};
    else
      addr = {pat_base, name, row[2:0]};
  end
endmodule

// File: rtl/spr_slot_bank.sv
module spr_slot_bank #(
  parameter int unsigned SLOT_CNT = 4,
  localparam int unsigned SLOT_W  = $clog2(SLOT_CNT),
  localparam int unsigned FLAT_W  = SLOT_CNT * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [2:0]        wr_field,
  input  logic [7:0]        wr_data,
  output logic [SLOT_CNT-1:0] valid,
  output logic [FLAT_W-1:0] f_ypos,
  output logic [FLAT_W-1:0] f_xpos,
  output logic [FLAT_W-1:0] f_name,
  output logic [FLAT_W-1:0] f_color,
  output logic [FLAT_W-1:0] f_pat_l,
  output logic [FLAT_W-1:0] f_pat_r
);
  for (genvar s = 0; s < SLOT_CNT; s++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_slot == SLOT_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid[s]           <= 1'b0;
        f_ypos[s*8 +: 8]   <= '0;
        f_xpos[s*8 +: 8]   <= '0;
        f_name[s*8 +: 8]   <= '0;
        f_color[s*8 +: 8]  <= '0;
        f_pat_l[s*8 +: 8]  <= '0;
        f_pat_r[s*8 +: 8]  <= '0;
      end else if (clr) begin
        valid[s]           <= 1'b0;
        f_ypos[s*8 +: 8]   <= '0;
        f_xpos[s*8 +: 8]   <= '0;
        f_name[s*8 +: 8]   <= '0;
        f_color[s*8 +: 8]  <= '0;
        f_pat_l[s*8 +: 8]  <= '0;
        f_pat_r[s*8 +: 8]  <= '0;
      end else if (hit) begin
        case (wr_field)
          3'd0:    f_ypos[s*8 +: 8]  <= wr_data;
          3'd1:    f_xpos[s*8 +: 8]  <= wr_data;
          3'd2:    f_name[s*8 +: 8]  <= wr_data;
          3'd3:    f_color[s*8 +: 8] <= wr_data;
          3'd4:    f_pat_l[s*8 +: 8] <= wr_data;
          default: begin
            f_pat_r[s*8 +: 8] <= wr_data;
            valid[s]          <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/sprite_line_eval.sv
module sprite_line_eval
  import sprite_eval_pkg::*;
#(
  parameter int unsigned SPR_CNT  = 32,
  parameter int unsigned SLOT_CNT = 4,
  parameter int unsigned VA_W     = 14,
  localparam int unsigned IDX_W   = $clog2(SPR_CNT),
  localparam int unsigned SLOT_W  = $clog2(SLOT_CNT),
  localparam int unsigned SAT_W   = VA_W - IDX_W - 2,
  localparam int unsigned PAT_W   = VA_W - 11,
  localparam int unsigned FLAT_W  = SLOT_CNT * 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_start,
  input  logic [7:0]          line_num,
  input  logic [SAT_W-1:0]    sat_base,
  input  logic [PAT_W-1:0]    pat_base,
  input  logic                size16,
  input  logic                mag,
  input  logic                status_rd,
  output logic                rd_req_valid,
  input  logic                rd_req_ready,
  output logic [VA_W-1:0]     rd_addr,
  input  logic                rd_rsp_valid,
  input  logic [7:0]          rd_rsp_data,
  output logic [SLOT_CNT-1:0] slot_valid,
  output logic [FLAT_W-1:0]   slot_ypos,
  output logic [FLAT_W-1:0]   slot_xpos,
  output logic [FLAT_W-1:0]   slot_name,
  output logic [FLAT_W-1:0]   slot_color,
  output logic [FLAT_W-1:0]   slot_pat_l,
  output logic [FLAT_W-1:0]   slot_pat_r,
  output logic                fifth_flag,
  output logic [IDX_W-1:0]    fifth_num,
  output logic                done
);
  ev_state_t          st;
  logic [IDX_W-1:0]   idx;
  logic [STEP_W-1:0]  step;
  logic [SLOT_W:0]    used;
  logic [7:0]         cur_y;
  logic [7:0]         cur_name;

  logic               probe_rsp;
  logic               fetch_rsp;
  logic               last_idx;
  logic               slots_full;
  logic               set_fifth;
  logic [7:0]         ysel;
  logic               covers;
  logic [3:0]         prow;
  logic [7:0]         slot_data;

  assign probe_rsp  = (st == EV_WAIT) && rd_rsp_valid && (step == '0);
  assign fetch_rsp  = (st == EV_WAIT) && rd_rsp_valid && (step != '0);
  assign last_idx   = (idx == IDX_W'(SPR_CNT - 1));
  assign slots_full = (used == (SLOT_W + 1)'(SLOT_CNT));
  assign ysel       = probe_rsp ? rd_rsp_data : cur_y;
  assign set_fifth  = probe_rsp && (rd_rsp_data != END_MARKER) && covers && slots_full;
  assign slot_data  = ((step == STEP_W'(LAST_STEP)) && !size16) ? 8'h00 : rd_rsp_data;

  spr_vcheck u_vcheck (
    .line_num (line_num),
    .ypos     (ysel),
    .size16   (size16),
    .mag      (mag),
    .act      (covers),
    .row      (prow)
  );

  spr_addr_gen #(.VA_W(VA_W), .IDX_W(IDX_W)) u_addr (
    .sat_base (sat_base),
    .pat_base (pat_base),
    .idx      (idx),
    .step     (step),
    .name     (cur_name),
    .row      (prow),
    .size16   (size16),
    .addr     (rd_addr)
  );

  spr_slot_bank #(.SLOT_CNT(SLOT_CNT)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (line_start),
    .wr_en    (fetch_rsp),
    .wr_slot  (used[SLOT_W-1:0]),
    .wr_field (step - 3'd1),
    .wr_data  (slot_data),
    .valid    (slot_valid),
    .f_ypos   (slot_ypos),
    .f_xpos   (slot_xpos),
    .f_name   (slot_name),
    .f_color  (slot_color),
    .f_pat_l  (slot_pat_l),
    .f_pat_r  (slot_pat_r)
  );

  assign rd_req_valid = (st == EV_REQ);
  assign done         = (st == EV_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= EV_IDLE;
      idx      <= '0;
      step     <= '0;
      used     <= '0;
      cur_y    <= '0;
      cur_name <= '0;
    end else if (line_start) begin
      st   <= EV_REQ;
      idx  <= '0;
      step <= '0;
      used <= '0;
    end else begin
      case (st)
        EV_REQ: if (rd_req_ready) st <= EV_WAIT;
        EV_WAIT: begin
          if (probe_rsp) begin
            cur_y <= rd_rsp_data;
            if (rd_rsp_data == END_MARKER || set_fifth) begin
              st <= EV_DONE;
            end else if (covers) begin
              step <= 3'd1;
              st   <= EV_REQ;
            end else if (last_idx) begin
              st <= EV_DONE;
            end else begin
              idx <= idx + 1'b1;
              st  <= EV_REQ;
            end
          end else if (fetch_rsp) begin
            if (step == 3'd3) cur_name <= rd_rsp_data;
            if (step == STEP_W'(LAST_STEP)) begin
              step <= '0;
              used <= used + 1'b1;
              if (last_idx) st <= EV_DONE;
              else begin
                idx <= idx + 1'b1;
                st  <= EV_REQ;
              end
            end else begin
              step <= step + 1'b1;
              st   <= EV_REQ;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifth_flag <= 1'b0;
      fifth_num  <= '0;
    end else if (set_fifth) begin
      fifth_flag <= 1'b1;
      if (!fifth_flag) fifth_num <= idx;
    end else if (status_rd) begin
      fifth_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/sprite_line_eval_chk.sv
module sprite_line_eval_chk #(
  parameter int unsigned SLOT_CNT = 4,
  parameter int unsigned VA_W     = 14,
  parameter int unsigned IDX_W    = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                line_start,
  input logic                status_rd,
  input logic                rd_req_valid,
  input logic                rd_req_ready,
  input logic [VA_W-1:0]     rd_addr,
  input logic [SLOT_CNT-1:0] slot_valid,
  input logic                fifth_flag,
  input logic [IDX_W-1:0]    fifth_num,
  input logic                done
);
  logic [SLOT_CNT-1:0] sv_inc;
  assign sv_inc = slot_valid + SLOT_CNT'(1);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready && !line_start |=> rd_req_valid && $stable(rd_addr));

  // R2
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req_valid);

  // R6
  fill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid & sv_inc) == '0);

  // R7
  fifth_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifth_flag) |-> (&slot_valid) && done);

  // R8
  fifth_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifth_flag && !status_rd |=> fifth_flag && $stable(fifth_num));

  // R10
  restart_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> slot_valid == '0 && !done);
endmodule

bind sprite_line_eval sprite_line_eval_chk #(
  .SLOT_CNT(SLOT_CNT), .VA_W(VA_W), .IDX_W(IDX_W)
) chk_i (.*);

// File: tb/sprite_line_eval_tb_top.sv
module sprite_line_eval_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_start = 1'b0;
  logic [7:0]  line_num = '0;
  logic [6:0]  sat_base = 7'h3F;
  logic [2:0]  pat_base = 3'h1;
  logic        size16 = 1'b0;
  logic        mag = 1'b0;
  logic        status_rd = 1'b0;
  logic        rd_req_valid;
  logic        rd_req_ready = 1'b0;
  logic [13:0] rd_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [7:0]  rd_rsp_data = '0;
  logic [3:0]  slot_valid;
  logic [31:0] slot_ypos, slot_xpos, slot_name, slot_color, slot_pat_l, slot_pat_r;
  logic        fifth_flag;
  logic [4:0]  fifth_num;
  logic        done;

  int checks = 0;
  int errors = 0;
  logic [13:0] exp_q[$];
  logic [7:0]  sat_mem [0:127];

  // expected per-line results
  int          e_cnt;
  logic [7:0]  e_f[4][6];
  logic        m_flag = 1'b0;
  logic [4:0]  m_num = '0;

  always #2 clk = ~clk;

  sprite_line_eval dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] vram_rd(input logic [13:0] a);
    if (a[13:7] == sat_base) return sat_mem[a[6:0]];
    return a[7:0] ^ {a[12:8], a[13], 2'b10};
  endfunction

  function automatic logic [13:0] pat_addr(input logic [7:0] nm, input logic [3:0] row, input bit col);
    if (size16) return {pat_base, nm[7:2], col, row};
    return {pat_base, nm, row[2:0]};
  endfunction

  // memory model and scoreboard monitor
  int  lat = 0;
  bit  pend = 1'b0;
  logic [13:0] pend_addr;
  always @(negedge clk) begin
    rd_rsp_valid = 1'b0;
    if (pend) begin
      if (lat == 0) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = vram_rd(pend_addr);
        pend = 1'b0;
      end else lat--;
      rd_req_ready = 1'b0;
    end else begin
      rd_req_ready = ($urandom_range(0, 3) != 0);
      if (rd_req_valid && rd_req_ready) begin
        pend_addr = rd_addr;
        pend = 1'b1;
        lat  = $urandom_range(0, 2);
        if (exp_q.size() == 0)
          chk(1'b0, "R2 unexpected read", int'(rd_addr), 0);
        else begin
          logic [13:0] e;
          e = exp_q.pop_front();
          chk(rd_addr == e, "R1/R4/R5 read address", int'(rd_addr), int'(e));
        end
      end
    end
  end

  task automatic clear_sat();
    for (int i = 0; i < 128; i++) sat_mem[i] = (i % 4 == 0) ? 8'hC0 : 8'(i * 7 + 3);
  endtask

  task automatic set_spr(input int n, input logic [7:0] y, x, nm, col);
    sat_mem[n*4] = y; sat_mem[n*4+1] = x; sat_mem[n*4+2] = nm; sat_mem[n*4+3] = col;
  endtask

  // driver: builds the expected read stream and slot contents
  task automatic predict(input logic [7:0] ln);
    logic [7:0] h, off, y, nm;
    logic [3:0] row;
    e_cnt = 0;
    for (int k = 0; k < 4; k++) for (int f = 0; f < 6; f++) e_f[k][f] = '0;
    for (int n = 0; n < 32; n++) begin
      exp_q.push_back({sat_base, 5'(n), 2'b00});
      y = sat_mem[n*4];
      if (y == 8'hD0) break;
      off = ln - y - 8'd1;
      h = size16 ? 8'd16 : 8'd8;
      if (mag) h = h * 2;
      if (off < h) begin
        if (e_cnt == 4) begin
          if (!m_flag) m_num = 5'(n);
          m_flag = 1'b1;
          break;
        end
        for (int b = 0; b < 4; b++) begin
          exp_q.push_back({sat_base, 5'(n), 2'(b)});
          e_f[e_cnt][b] = sat_mem[n*4+b];
        end
        nm  = sat_mem[n*4+2];
        row = mag ? off[4:1] : off[3:0];
        exp_q.push_back(pat_addr(nm, row, 1'b0));
        exp_q.push_back(pat_addr(nm, row, 1'b1));
        e_f[e_cnt][4] = vram_rd(pat_addr(nm, row, 1'b0));
        e_f[e_cnt][5] = size16 ? vram_rd(pat_addr(nm, row, 1'b1)) : 8'h00;
        e_cnt++;
      end
    end
  endtask

  task automatic run_line(input logic [7:0] ln, input string tag);
    int n;
    line_num = ln;
    predict(ln);
    @(negedge clk) line_start = 1'b1;
    @(negedge clk) line_start = 1'b0;
    n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    chk(done == 1'b1, {tag, " R9 done reached"}, done, 1);
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, {tag, " R1 all reads issued"}, exp_q.size(), 0);
    exp_q.delete();
    chk(slot_valid == 4'((1 << e_cnt) - 1), {tag, " R6 slot_valid"}, slot_valid, (1 << e_cnt) - 1);
    for (int k = 0; k < 4; k++) begin
      chk(slot_ypos[k*8 +: 8]  == e_f[k][0], {tag, " R4 ypos"},  slot_ypos[k*8 +: 8],  e_f[k][0]);
      chk(slot_xpos[k*8 +: 8]  == e_f[k][1], {tag, " R4 xpos"},  slot_xpos[k*8 +: 8],  e_f[k][1]);
      chk(slot_name[k*8 +: 8]  == e_f[k][2], {tag, " R4 name"},  slot_name[k*8 +: 8],  e_f[k][2]);
      chk(slot_color[k*8 +: 8] == e_f[k][3], {tag, " R4 color"}, slot_color[k*8 +: 8], e_f[k][3]);
      chk(slot_pat_l[k*8 +: 8] == e_f[k][4], {tag, " R5 pat_l"}, slot_pat_l[k*8 +: 8], e_f[k][4]);
      chk(slot_pat_r[k*8 +: 8] == e_f[k][5], {tag, " R5 pat_r"}, slot_pat_r[k*8 +: 8], e_f[k][5]);
    end
    chk(fifth_flag == m_flag, {tag, " R7 fifth_flag"}, fifth_flag, m_flag);
    if (m_flag) chk(fifth_num == m_num, {tag, " R7/R8 fifth_num"}, fifth_num, m_num);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_sat();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(done == 0 && slot_valid == 0 && fifth_flag == 0 && rd_req_valid == 0,
        "R10 reset state", {done, slot_valid, fifth_flag, rd_req_valid}, 0);

    // R2 R3: terminator at 4, off-left and transparent sprites still selected
    set_spr(0, 8'd19, 8'd90, 8'h21, 8'h07);
    set_spr(1, 8'd100, 8'd10, 8'h22, 8'h05);
    set_spr(2, 8'd12, 8'd0, 8'h33, 8'h00);
    set_spr(3, 8'd13, 8'd250, 8'h44, 8'h80);
    sat_mem[16] = 8'hD0;
    run_line(8'd20, "A");

    // R9: no terminator, sprite 31 takes the fourth slot
    sat_mem[16] = 8'hC0;
    set_spr(31, 8'd15, 8'd4, 8'h5A, 8'h0C);
    run_line(8'd20, "B");

    // R7: magnified 8x8, six covering sprites
    clear_sat();
    mag = 1'b1;
    set_spr(2, 8'd35, 8'd1, 8'h10, 8'h01);
    set_spr(5, 8'd40, 8'd2, 8'h11, 8'h02);
    set_spr(7, 8'd49, 8'd3, 8'h12, 8'h03);
    set_spr(9, 8'd45, 8'd4, 8'h13, 8'h04);
    set_spr(12, 8'd38, 8'd5, 8'h14, 8'h05);
    set_spr(20, 8'd44, 8'd6, 8'h15, 8'h06);
    run_line(8'd50, "C");

    // R8: overflow at 5 on the next line keeps number 12
    clear_sat();
    for (int n = 1; n <= 6; n++) set_spr(n, 8'd45, 8'(n), 8'(n + 8'h60), 8'h09);
    run_line(8'd50, "D");
    chk(fifth_num == 5'd12, "R8 number kept while flag set", fifth_num, 12);
    @(negedge clk) status_rd = 1'b1;
    @(negedge clk) status_rd = 1'b0;
    chk(fifth_flag == 1'b0, "R8 status_rd clears flag", fifth_flag, 0);
    m_flag = 1'b0;
    run_line(8'd50, "D2");
    chk(fifth_num == 5'd5, "R8 new number after clear", fifth_num, 5);

    // R3 R5: 16x16 with vertical wrap
    clear_sat();
    mag = 1'b0; size16 = 1'b1;
    set_spr(0, 8'hF8, 8'd30, 8'h47, 8'h0F);
    set_spr(1, 8'hFF, 8'd31, 8'h13, 8'h0E);
    set_spr(2, 8'h00, 8'd32, 8'hFE, 8'h0D);
    sat_mem[12] = 8'hD0;
    run_line(8'd2, "E");

    // R3 R5: 16x16 magnified height edge
    clear_sat();
    mag = 1'b1;
    set_spr(0, 8'd9, 8'd0, 8'h81, 8'h01);
    set_spr(1, 8'd8, 8'd0, 8'h82, 8'h02);
    set_spr(2, 8'd7, 8'd0, 8'h83, 8'h03);
    sat_mem[12] = 8'hD0;
    run_line(8'd40, "F");

    // R2 R10: terminator at sprite 0 clears previous slots
    sat_mem[0] = 8'hD0;
    run_line(8'd40, "G");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule